// File: doc/BRIEF.md
# Dual-Domain Reset Sequencer with Completion Flag

This block generates the reset for two clock domains: a fast interface clock and a slower, unrelated debounce clock. It takes two sources. The first is an active-low hardware reset pin. The second is a software reset, started by a one-cycle write strobe in the interface domain.

Each domain receives its own reset. That reset asserts asynchronously as soon as either source becomes active. It is released synchronously, through a chain of flops clocked by that domain.

A completion flag in the interface domain reports when reset has finished in both domains. The debounce domain's release is carried back to the interface clock through a synchronizer before the flag can rise. A software reset drives exactly the same path as the hardware pin. It holds both domains in reset for a fixed number of interface cycles, then lets them go. Its readback bit clears by itself once the completion flag has been seen.

Top module: `dual_domain_reset`

## Requirements
- R1: While `hw_rst_n` is 0, `rst_if_n`, `rst_db_n` and `rst_done` are 0, without waiting for any clock edge.
- R2: After `hw_rst_n` returns to 1, `rst_if_n` stays 0 through the first `clk_if` rising edge and becomes 1 on the second (SYNC_STAGES = 2).
- R3: After `hw_rst_n` returns to 1, `rst_db_n` stays 0 through the first `clk_db` rising edge and becomes 1 on the second.
- R4: `rst_done` is 1 only while both `rst_if_n` and `rst_db_n` are 1. After any reset it rises within 40 `clk_if` cycles, and no earlier than one edge after `rst_if_n` is released.
- R5: When `sw_rst_wr` is 1 at a `clk_if` rising edge and no software reset is in progress, both domain resets and `rst_done` go to 0 right after that edge. `rst_if_n` is released on the edge SW_HOLD + SYNC_STAGES edges later, which is the 6th with the defaults.
- R6: `sw_rst_bit` reads 1 from the edge that accepts the write until `rst_done` has risen. It reads 0 one edge after that.
- R7: After a software reset, `rst_done` obeys the same rule as R4.
- R8: A `sw_rst_wr` strobe during a software reset already in progress is ignored: the release edge of R5 does not move.
- R9: A `sw_rst_wr` strobe while `hw_rst_n` is 0 is ignored. After the pin is released, `sw_rst_bit` reads 0 and `rst_if_n` follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_if | input | 1 | Interface clock |
| clk_db | input | 1 | Debounce clock, unrelated to clk_if |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst_wr | input | 1 | Strobe that writes 1 to the software reset bit |
| sw_rst_bit | output | 1 | Readback of the software reset bit |
| rst_if_n | output | 1 | Reset for the interface domain, active low |
| rst_db_n | output | 1 | Reset for the debounce domain, active low |
| rst_done | output | 1 | Reset complete in both domains |

## Verification
Results arrive on different schedules.

- **Assertion:** the reset outputs follow either source asynchronously. The bench samples them 1 ns after the source changes.
- **Interface-domain release:** this is due on the 2nd `clk_if` edge after a pin release, or the 6th after an accepted write. The bench counts edges and samples on the falling edge that follows each one.
- **Debounce-domain release:** this is due on the 2nd `clk_db` edge. For that check the pin is released on a `clk_db` falling edge, and the output is sampled 1 ns after each rising edge.
- **Completion flag:** its timing depends on the phase between the two clocks. The bench therefore polls it within a bounded window, checks both resets are released when it is seen, and expects the readback bit to clear exactly one `clk_if` edge later.

// File: rtl/rstq_pkg.sv
package rstq_pkg;

  // True on the last cycle of a software reset hold window of length hold_len
  function automatic logic hold_last(input int unsigned cnt, input int unsigned hold_len);
    return (cnt + 1) == hold_len;
  endfunction

  // Interface edge, counted from the accepting edge, on which the interface reset releases
  function automatic int unsigned sw_release_edge(input int unsigned hold_len,
                                                  input int unsigned stages);
    return hold_len + stages;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = chain_q[STAGES-1];

  initial begin
    AST_STAGES_MIN: assert (STAGES >= 2); // R2
  end

  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out_n |-> $past(arst_n)); // R2

endmodule

// File: rtl/sw_rst_ctrl.sv
module sw_rst_ctrl
  import rstq_pkg::*;
#(
  parameter int unsigned SW_HOLD = 4
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic wr,
  input  logic done,
  output logic hold,
  output logic busy
);

  localparam int unsigned CNT_W = (SW_HOLD < 2) ? 1 : $clog2(SW_HOLD);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             hold_end;
  logic             finish;

  assign accept   = wr && !busy;
  assign hold_end = hold_last(32'(cnt_q), SW_HOLD);
  assign finish   = busy && !hold && done;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      busy  <= 1'b0;
      hold  <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      hold  <= 1'b1;
      cnt_q <= '0;
    end else if (hold) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (hold_end) hold <= 1'b0;
    end else if (finish) begin
      busy <= 1'b0;
    end
  end

  AST_HOLD_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!hw_rst_n)
    hold |-> busy); // R5
  AST_BUSY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $fell(busy) |-> $past(done)); // R6
  AST_REWRITE_IGNORED: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (busy && wr && !hold) |=> !hold); // R8

endmodule

// File: rtl/done_tracker.sv
module done_tracker #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_if,
  input  logic raw_n,
  input  logic if_rst_n,
  input  logic db_rst_n,
  output logic done
);

  logic db_seen;

  // Debounce-domain release brought into the interface clock
  rst_sync #(.STAGES(STAGES)) u_db_back (
    .clk      (clk_if),
    .arst_n   (db_rst_n),
    .rst_out_n(db_seen)
  );

  always_ff @(posedge clk_if or negedge raw_n) begin
    if (!raw_n) done <= 1'b0;
    else        done <= if_rst_n && db_seen;
  end

  AST_DONE_NEEDS_BOTH: assert property (@(posedge clk_if) disable iff (!raw_n)
    done |-> (if_rst_n && db_seen)); // R4
  AST_DONE_AFTER_IF: assert property (@(posedge clk_if) disable iff (!raw_n)
    $rose(done) |-> $past(if_rst_n)); // R4

endmodule

// File: rtl/dual_domain_reset.sv
module dual_domain_reset #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SW_HOLD     = 4
) (
  input  logic clk_if,
  input  logic clk_db,
  input  logic hw_rst_n,
  input  logic sw_rst_wr,
  output logic sw_rst_bit,
  output logic rst_if_n,
  output logic rst_db_n,
  output logic rst_done
);

  logic sw_hold;
  logic raw_n;

  assign raw_n = hw_rst_n && !sw_hold;

  sw_rst_ctrl #(.SW_HOLD(SW_HOLD)) u_sw (
    .clk     (clk_if),
    .hw_rst_n(hw_rst_n),
    .wr      (sw_rst_wr),
    .done    (rst_done),
    .hold    (sw_hold),
    .busy    (sw_rst_bit)
  );

  rst_sync #(.STAGES(SYNC_STAGES)) u_if_sync (
    .clk      (clk_if),
    .arst_n   (raw_n),
    .rst_out_n(rst_if_n)
  );

  rst_sync #(.STAGES(SYNC_STAGES)) u_db_sync (
    .clk      (clk_db),
    .arst_n   (raw_n),
    .rst_out_n(rst_db_n)
  );

  done_tracker #(.STAGES(SYNC_STAGES)) u_done (
    .clk_if  (clk_if),
    .raw_n   (raw_n),
    .if_rst_n(rst_if_n),
    .db_rst_n(rst_db_n),
    .done    (rst_done)
  );

  AST_SW_HOLDS_IF: assert property (@(posedge clk_if) disable iff (!hw_rst_n)
    sw_hold |-> !rst_if_n); // R5
  AST_DONE_LOW_IN_HOLD: assert property (@(posedge clk_if) disable iff (!hw_rst_n)
    sw_hold |-> !rst_done); // R7
  AST_DONE_DB_RELEASED: assert property (@(posedge clk_if) disable iff (!hw_rst_n)
    rst_done |-> rst_db_n); // R4

endmodule

// File: tb/test_dual_domain_reset.sv
module test_dual_domain_reset;

  localparam int unsigned IF_PERIOD = 10;
  localparam int unsigned DB_PERIOD = 34;
  localparam int unsigned STAGES    = 2;
  localparam int unsigned HOLD      = 4;
  localparam int unsigned REL_EDGE  = HOLD + STAGES;
  localparam int unsigned NVEC      = 4;
  // Vector table: idle cycles before the write, edge of a repeated write (0 = none),
  // expected release edge of rst_if_n
  localparam int unsigned V_IDLE [NVEC] = '{1, 3, 0, 2};
  localparam int unsigned V_REWR [NVEC] = '{0, 2, 5, 1};
  localparam int unsigned V_EXP  [NVEC] = '{REL_EDGE, REL_EDGE, REL_EDGE, REL_EDGE};

  logic clk_if = 1'b0;
  logic clk_db = 1'b0;
  logic hw_rst_n;
  logic sw_rst_wr;
  logic sw_rst_bit;
  logic rst_if_n;
  logic rst_db_n;
  logic rst_done;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(IF_PERIOD / 2) clk_if = ~clk_if;
  always #(DB_PERIOD / 2) clk_db = ~clk_db;

  dual_domain_reset #(.SYNC_STAGES(STAGES), .SW_HOLD(HOLD)) i_dual_domain_reset (
    .clk_if    (clk_if),
    .clk_db    (clk_db),
    .hw_rst_n  (hw_rst_n),
    .sw_rst_wr (sw_rst_wr),
    .sw_rst_bit(sw_rst_bit),
    .rst_if_n  (rst_if_n),
    .rst_db_n  (rst_db_n),
    .rst_done  (rst_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Poll rst_done; once seen, both resets must be out and the bit clears one edge later
  task automatic wait_done(input string req);
    int seen = 0;
    for (int n = 0; n < 40 && seen == 0; n++) begin
      @(negedge clk_if);
      if (rst_done) seen = 1;
      else check(sw_rst_bit == 1'b1 || req == "R4", "R6", "bit before done", sw_rst_bit, 1);
    end
    check(seen == 1, req, "done within window", seen, 1);
    check(rst_if_n && rst_db_n, req, "both released at done", {rst_if_n, rst_db_n}, 3);
    @(negedge clk_if);
    check(sw_rst_bit == 1'b0, "R6", "bit one edge after done", sw_rst_bit, 0);
  endtask

  initial begin
    #(IF_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rel;
    hw_rst_n  = 1'b0;
    sw_rst_wr = 1'b1;
    #1;
    check({rst_if_n, rst_db_n, rst_done} == 3'b000, "R1", "outputs in reset",
          {rst_if_n, rst_db_n, rst_done}, 0);
    repeat (3) @(negedge clk_if);
    sw_rst_wr = 1'b0;
    hw_rst_n  = 1'b1;
    // R2 / R9: interface release on the second edge; write during reset ignored
    @(negedge clk_if);
    check(rst_if_n == 1'b0, "R2", "if after edge 1", rst_if_n, 0);
    check(sw_rst_bit == 1'b0, "R9", "bit after write in reset", sw_rst_bit, 0);
    @(negedge clk_if);
    check(rst_if_n == 1'b1, "R2", "if after edge 2", rst_if_n, 1);
    wait_done("R4");

    // R3: debounce release timed on clk_db
    @(negedge clk_db);
    hw_rst_n = 1'b0;
    #1;
    check({rst_if_n, rst_db_n, rst_done} == 3'b000, "R1", "async assert mid-run",
          {rst_if_n, rst_db_n, rst_done}, 0);
    @(negedge clk_db);
    hw_rst_n = 1'b1;
    @(posedge clk_db); #1;
    check(rst_db_n == 1'b0, "R3", "db after edge 1", rst_db_n, 0);
    @(posedge clk_db); #1;
    check(rst_db_n == 1'b1, "R3", "db after edge 2", rst_db_n, 1);
    wait_done("R4");

    // R5 / R7 / R8: software reset vectors
    for (int v = 0; v < NVEC; v++) begin
      repeat (V_IDLE[v]) @(negedge clk_if);
      @(negedge clk_if);
      sw_rst_wr = 1'b1;
      @(negedge clk_if);
      sw_rst_wr = 1'b0;
      check({rst_if_n, rst_db_n, rst_done} == 3'b000, "R5", "resets after write",
            {rst_if_n, rst_db_n, rst_done}, 0);
      check(sw_rst_bit == 1'b1, "R6", "bit after write", sw_rst_bit, 1);
      rel = 0;
      for (int n = 1; n <= 12; n++) begin
        sw_rst_wr = (n == int'(V_REWR[v]));
        @(negedge clk_if);
        sw_rst_wr = 1'b0;
        if (rel == 0 && rst_if_n) begin
          rel = n;
          check(rst_done == 1'b0, "R7", "done not with if release", rst_done, 0);
        end
        if (rst_done) break;
      end
      check(rel == int'(V_EXP[v]), (V_REWR[v] != 0) ? "R8" : "R5", "release edge",
            rel, int'(V_EXP[v]));
      wait_done("R7");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule